// File: doc/BRIEF.md
# RC5 Run-Length Frame Decoder

This block rebuilds an RC5 bi-phase frame from a stream of level-tagged run lengths. An infrared receiver front end has already measured the pin: each byte it delivers gives a line level and how many sample cycles that level lasted. The decoder joins neighbouring bytes of equal level into one run and checks each run against one or two half-bit units, with a fixed tolerance. A three-phase state machine then recovers the data bits. When a long trailer run appears, the block emits a 13-bit scancode made of a 5-bit system address and a 7-bit command, together with a one-cycle done pulse.

Software or a sequencer pulses `frame_start` before each capture. Bytes flow in over a valid/ready handshake. A one-cycle error pulse flags a frame whose first run is too short to be a start half-bit. A run of two units is handled by consuming one unit and evaluating the remainder again in the next phase. This means a bit boundary that falls inside one long run is still decoded in the same cycle.

Top module: `rc5_rl_decoder`

## Requirements
- R1: Input byte bit 7 is the line level (1 = high, 0 = low) and bits 6:0 are a duration in sample cycles. Consecutive accepted bytes of equal level are added into one run. A run is classified when a byte of the other level is accepted, or as soon as its sum exceeds the trailer threshold of 310 cycles.
- R2: A run matches one unit when it lies in 22..42 cycles and two units when it lies in 54..74 cycles, both bounds inclusive. A run that is not more than 22 cycles long is too short to be a start half-bit.
- R3: In the idle phase, a run of 22 cycles or less raises `err` for one cycle, in the cycle after the byte that closes the run. A two-unit run has 32 removed and the remainder is evaluated in the bit-start phase in the same cycle. A one-unit run moves to bit-start.
- R4: In the bit-start phase, a one-unit run shifts the frame register left and appends 1 for a low run and 0 for a high run, then moves to bit-end. A run of any other length up to 310 cycles is ignored and leaves the phase unchanged.
- R5: In the bit-end phase, a two-unit run has 32 consumed and the remainder is evaluated as bit-start. A one-unit run returns to bit-start. A run above 310 cycles ends the frame.
- R6: A run above 310 cycles in the bit-start phase ends the frame. The output fields are: `code[5:0]` = frame bits 5:0; `code[6]` = inverse of frame bit 12; `code[7]` = 0; `code[12:8]` = frame bits 10:6. `code_valid` is high for exactly one cycle, in the cycle after the byte that completes the frame is accepted.
- R7: After a frame ends the decoder is idle. Further bytes of the same level as the long run that ended the frame are ignored, so a short leftover trailer byte raises no error.
- R8: `frame_start` discards the pending run, clears the frame register and returns to idle. While it is high, `in_ready` is low and no byte is accepted.
- R9: `code_valid` and `err` are never high together, and `code` keeps its last value until the next frame ends. After reset all outputs are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Strobe that begins a new capture |
| in_valid | input | 1 | Run-length byte valid |
| in_data | input | 8 | Bit 7 level, bits 6:0 duration |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| code_valid | output | 1 | One-cycle pulse: scancode ready |
| code | output | 13 | System address and command |
| err | output | 1 | One-cycle pulse: first run too short |

## Verification
The main function is driven with random 13-bit frames. Each half-bit carries random jitter of up to four cycles, and each run is cut into randomly sized bytes with random idle gaps. This separates a correct run merger from one that classifies every byte on its own. Two frames with every half-bit held at the edge of the tolerance window (27 and 37 cycles) show whether the inclusive bounds are right for both one-unit and two-unit runs. Directed streams cover the remaining cases: a 22-cycle versus a 23-cycle first run, an 80-cycle run ignored in bit-start, a capture aborted by `frame_start`, and a trailer whose short leftover byte must not read as a new frame's error.

// File: rtl/rc5_rl_pkg.sv
package rc5_rl_pkg;

    // Half-bit decoding phase
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_END   = 2'd2
    } phase_e;

    // Number of bi-phase bits shifted into the frame register
    localparam int FRAME_BITS = 13;

endpackage

// File: rtl/rc5_phase_step.sv
// One evaluation of a closed run in the half-bit state machine.
// Two instances are chained so that a split double-unit run is
// re-evaluated in the same cycle.
module rc5_phase_step
    import rc5_rl_pkg::*;
#(
    parameter int UNIT        = 32,
    parameter int MARGIN      = 10,
    parameter int TRAIL_UNITS = 10,
    parameter int ACC_W       = 12,
    parameter int DATA_W      = FRAME_BITS
) (
    input  logic              en_i,
    input  phase_e            phase_i,
    input  logic [ACC_W-1:0]  len_i,
    input  logic              lvl_i,
    input  logic [DATA_W-1:0] data_i,
    output phase_e            phase_o,
    output logic [ACC_W-1:0]  len_o,
    output logic              again_o,
    output logic [DATA_W-1:0] data_o,
    output logic              done_o,
    output logic              err_o
);

    localparam logic [ACC_W-1:0] ONE_LO    = ACC_W'(UNIT - MARGIN);
    localparam logic [ACC_W-1:0] ONE_HI    = ACC_W'(UNIT + MARGIN);
    localparam logic [ACC_W-1:0] TWO_LO    = ACC_W'(2 * UNIT - MARGIN);
    localparam logic [ACC_W-1:0] TWO_HI    = ACC_W'(2 * UNIT + MARGIN);
    localparam logic [ACC_W-1:0] TRAIL_MIN = ACC_W'(TRAIL_UNITS * UNIT - MARGIN);
    localparam logic [ACC_W-1:0] UNIT_LEN  = ACC_W'(UNIT);

    logic is_one;
    logic is_two;
    logic is_trail;

    assign is_one   = (len_i >= ONE_LO) && (len_i <= ONE_HI);
    assign is_two   = (len_i >= TWO_LO) && (len_i <= TWO_HI);
    assign is_trail = (len_i > TRAIL_MIN);

    always_comb begin
        phase_o = phase_i;
        len_o   = len_i;
        again_o = 1'b0;
        data_o  = data_i;
        done_o  = 1'b0;
        err_o   = 1'b0;
        if (en_i) begin
            unique case (phase_i)
                PH_IDLE: begin
                    if (len_i <= ONE_LO) begin
                        err_o = 1'b1;
                    end else if (is_two) begin
                        len_o   = len_i - UNIT_LEN;
                        again_o = 1'b1;
                        phase_o = PH_START;
                        data_o  = '0;
                    end else if (is_one) begin
                        phase_o = PH_START;
                        data_o  = '0;
                    end
                end
                PH_START: begin
                    if (is_trail) begin
                        done_o  = 1'b1;
                        phase_o = PH_IDLE;
                    end else if (is_one) begin
                        data_o  = {data_i[DATA_W-2:0], ~lvl_i};
                        phase_o = PH_END;
                    end
                end
                PH_END: begin
                    if (is_two) begin
                        len_o   = len_i - UNIT_LEN;
                        again_o = 1'b1;
                        phase_o = PH_START;
                    end else if (is_one) begin
                        phase_o = PH_START;
                    end else if (is_trail) begin
                        done_o  = 1'b1;
                        phase_o = PH_IDLE;
                    end
                end
                default: phase_o = PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rc5_scan_pack.sv
// Maps the shifted frame bits onto the scancode layout.
module rc5_scan_pack
    import rc5_rl_pkg::*;
(
    input  logic [FRAME_BITS-1:0] frame_i,
    output logic [12:0]           code_o
);

    logic toggle_unused;
    assign toggle_unused = frame_i[11];

    always_comb begin
        code_o        = '0;
        code_o[5:0]   = frame_i[5:0];
        code_o[6]     = ~frame_i[12];
        code_o[12:8]  = frame_i[10:6];
    end

endmodule

// File: rtl/rc5_rl_decoder.sv
module rc5_rl_decoder
    import rc5_rl_pkg::*;
#(
    parameter int UNIT        = 32,
    parameter int MARGIN      = 10,
    parameter int TRAIL_UNITS = 10,
    parameter int ACC_W       = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_start,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    output logic        code_valid,
    output logic [12:0] code,
    output logic        err
);

    localparam int DATA_W = FRAME_BITS;
    localparam logic [ACC_W-1:0] TRAIL_MIN = ACC_W'(TRAIL_UNITS * UNIT - MARGIN);

    typedef struct packed {
        phase_e            phase;
        logic              have_run;
        logic              drain;
        logic              run_lvl;
        logic [ACC_W-1:0]  acc;
        logic [DATA_W-1:0] data;
        logic [12:0]       code;
        logic              done;
        logic              err;
    } dec_t;

    dec_t st_d, st_q;

    // Run closing controls
    logic             accept;
    logic             byte_lvl;
    logic [ACC_W-1:0] byte_len;
    logic [ACC_W-1:0] sum_len;
    logic             cls_en;
    logic [ACC_W-1:0] cls_len;

    // Chained evaluation stages
    phase_e            s1_phase, s2_phase;
    logic [ACC_W-1:0]  s1_len, len_rem_unused;
    logic              s1_again, s2_again;
    logic [DATA_W-1:0] s1_data, s2_data;
    logic              s1_done, s2_done;
    logic              s1_err, s2_err;
    logic [12:0]       packed_code;

    assign in_ready = ~frame_start;
    assign accept   = in_valid & in_ready;
    assign byte_lvl = in_data[7];
    assign byte_len = ACC_W'(in_data[6:0]);
    assign sum_len  = st_q.acc + byte_len;

    rc5_phase_step #(
        .UNIT(UNIT), .MARGIN(MARGIN), .TRAIL_UNITS(TRAIL_UNITS),
        .ACC_W(ACC_W), .DATA_W(DATA_W)
    ) u_step_a (
        .en_i(cls_en), .phase_i(st_q.phase), .len_i(cls_len),
        .lvl_i(st_q.run_lvl), .data_i(st_q.data),
        .phase_o(s1_phase), .len_o(s1_len), .again_o(s1_again),
        .data_o(s1_data), .done_o(s1_done), .err_o(s1_err)
    );

    rc5_phase_step #(
        .UNIT(UNIT), .MARGIN(MARGIN), .TRAIL_UNITS(TRAIL_UNITS),
        .ACC_W(ACC_W), .DATA_W(DATA_W)
    ) u_step_b (
        .en_i(s1_again), .phase_i(s1_phase), .len_i(s1_len),
        .lvl_i(st_q.run_lvl), .data_i(s1_data),
        .phase_o(s2_phase), .len_o(len_rem_unused), .again_o(s2_again),
        .data_o(s2_data), .done_o(s2_done), .err_o(s2_err)
    );

    rc5_scan_pack u_pack (
        .frame_i(s2_data),
        .code_o(packed_code)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        cls_en    = 1'b0;
        cls_len   = st_q.acc;
        if (frame_start) begin
            st_d.phase    = PH_IDLE;
            st_d.have_run = 1'b0;
            st_d.drain    = 1'b0;
            st_d.acc      = '0;
            st_d.data     = '0;
        end else if (accept) begin
            if (!st_q.have_run) begin
                st_d.have_run = 1'b1;
                st_d.drain    = 1'b0;
                st_d.run_lvl  = byte_lvl;
                st_d.acc      = byte_len;
            end else if (byte_lvl == st_q.run_lvl) begin
                if (!st_q.drain) begin
                    if (sum_len > TRAIL_MIN) begin
                        cls_en     = 1'b1;
                        cls_len    = sum_len;
                        st_d.drain = 1'b1;
                    end
                    st_d.acc = sum_len;
                end
            end else begin
                cls_en       = ~st_q.drain;
                st_d.drain   = 1'b0;
                st_d.run_lvl = byte_lvl;
                st_d.acc     = byte_len;
            end
            if (cls_en) begin
                st_d.phase = s2_phase;
                st_d.data  = s2_data;
                st_d.done  = s1_done | s2_done;
                st_d.err   = s1_err | s2_err;
                if (s1_done | s2_done) begin
                    st_d.code = packed_code;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign code_valid = st_q.done;
    assign code       = st_q.code;
    assign err        = st_q.err;

    // A split remainder lies in the one-unit window, so it never splits again (R3, R5)
    p_split_depth_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s1_again |-> !s2_again);

    // A finished frame leaves the decoder idle, and the next byte cannot end another (R7)
    p_idle_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> (st_q.phase == PH_IDLE));

    // Done is a single-cycle pulse (R6)
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |=> !code_valid);

    // Frame start produces no result in the following cycle (R8)
    p_start_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (!code_valid && !err));

    // Done and error never coincide (R9)
    p_done_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(code_valid && err));

    // Code only changes together with a done pulse (R9)
    p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_d.done |=> $stable(code));

endmodule

// File: tb/tb_rc5_rl_decoder.sv
`timescale 1ns/1ps
module tb_rc5_rl_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        code_valid;
    logic [12:0] code;
    logic        err;

    int n_tests = 0;
    int n_fail  = 0;
    int n_done  = 0;
    int n_err   = 0;
    logic [12:0] last_code = '0;
    bit finished = 0;

    logic lvls [0:79];
    int   lens [0:79];
    int   nr;

    always #2.5 clk = ~clk;

    rc5_rl_decoder dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .code_valid(code_valid), .code(code), .err(err)
    );

    always @(negedge clk) begin
        if (code_valid) begin
            n_done++;
            last_code = code;
        end
        if (err) n_err++;
    end

    function automatic logic [12:0] exp_code(input logic [12:0] raw);
        return {raw[10:6], 1'b0, ~raw[12], raw[5:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    function automatic int half(input int jmode);
        if (jmode == 99) return 32 + $urandom_range(8) - 4;
        return 32 + jmode;
    endfunction

    task automatic add_half(input logic lvl, input int d);
        if (nr > 0 && lvls[nr-1] == lvl) lens[nr-1] += d;
        else begin
            lvls[nr] = lvl;
            lens[nr] = d;
            nr++;
        end
    endtask

    task automatic build(input logic [12:0] raw, input int jmode, input int trail);
        nr = 0;
        add_half(1'b1, half(jmode));
        for (int b = 12; b >= 0; b--) begin
            if (raw[b]) begin
                add_half(1'b0, half(jmode));
                add_half(1'b1, half(jmode));
            end else begin
                add_half(1'b1, half(jmode));
                add_half(1'b0, half(jmode));
            end
        end
        add_half(1'b0, trail);
    endtask

    task automatic send_byte(input logic lvl, input int d, input bit gaps);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = {lvl, 7'(d)};
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        if (gaps) repeat ($urandom_range(2)) @(posedge clk);
    endtask

    task automatic send_runs(input int upto, input bit rnd_chunk);
        for (int i = 0; i < upto; i++) begin
            int rem = lens[i];
            while (rem > 0) begin
                int c = rnd_chunk ? int'($urandom_range(127, 1)) : 127;
                if (c > rem) c = rem;
                send_byte(lvls[i], c, rnd_chunk);
                rem -= c;
            end
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        frame_start = 1'b1;
        #1;
        chk(in_ready == 1'b0, "R8 in_ready low during frame_start", in_ready, 0);
        @(posedge clk);
        #1;
        frame_start = 1'b0;
    endtask

    task automatic settle_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_done = 0;
        n_err  = 0;
    endtask

    task automatic run_frame(input logic [12:0] raw, input int jmode, input bit rnd_chunk,
                             input int trail, input string tag);
        settle_clear();
        build(raw, jmode, trail);
        send_runs(nr, rnd_chunk);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(n_done == 1, {tag, " done count"}, n_done, 1);
        chk(last_code == exp_code(raw), {tag, " code"}, last_code, exp_code(raw));
        chk(n_err == 0, {tag, " no error"}, n_err, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk(code_valid == 0 && err == 0, "R9 reset pulses", {code_valid, err}, 0);
        chk(code == 0, "R9 reset code", code, 0);
        chk(in_ready == 1, "R9 reset in_ready", in_ready, 1);
        rst_n = 1'b1;

        // R2: tolerance edges, halves at 37 (double 74) and 27 (double 54)
        pulse_start();
        run_frame(13'h15A3, 5, 1'b1, 320, "R2 upper edge");
        pulse_start();
        run_frame(13'h0A5C, -5, 1'b1, 320, "R2 lower edge");

        // R5: last bit 0, trailer merges with bit-end half
        pulse_start();
        run_frame(13'h1FFE, 0, 1'b0, 320, "R5 bit-end trailer");
        // R3: leading zero bit forces the idle split
        pulse_start();
        run_frame(13'h0001, 0, 1'b0, 320, "R3 idle split");

        // R3: first run of 22 is an error
        pulse_start();
        settle_clear();
        send_byte(1'b1, 22, 1'b0);
        send_byte(1'b0, 32, 1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(n_err == 1, "R3 short first run error", n_err, 1);
        chk(n_done == 0, "R3 short first run no code", n_done, 0);

        // R3: first run of 23 accepted, then trailer gives empty frame
        pulse_start();
        settle_clear();
        send_byte(1'b1, 23, 1'b0);
        send_byte(1'b0, 127, 1'b0);
        send_byte(1'b0, 127, 1'b0);
        send_byte(1'b0, 127, 1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(n_err == 0, "R3 first run 23 no error", n_err, 0);
        chk(n_done == 1 && last_code == 13'h0040, "R3 first run 23 code", last_code, 13'h0040);

        // R4: an 80-cycle run in bit-start is ignored
        pulse_start();
        settle_clear();
        send_byte(1'b1, 32, 1'b0);
        send_byte(1'b0, 80, 1'b0);
        send_byte(1'b1, 127, 1'b0);
        send_byte(1'b1, 127, 1'b0);
        send_byte(1'b1, 80, 1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(n_done == 1 && last_code == 13'h0040, "R4 ignored run", last_code, 13'h0040);

        // R8: partial frame discarded by frame_start
        pulse_start();
        settle_clear();
        build(13'h1234, 0, 320);
        send_runs(10, 1'b0);
        pulse_start();
        run_frame(13'h0B6D, 99, 1'b1, 320, "R8 restart");

        // R7: trailer leftover of 20 cycles after the frame ends
        pulse_start();
        run_frame(13'h1C71, 0, 1'b0, 401, "R7 leftover trailer");
        run_frame(13'h02C8, 0, 1'b0, 320, "R7 next frame");

        // R9: code holds with no new frame
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(code == exp_code(13'h02C8), "R9 code hold", code, exp_code(13'h02C8));

        // R1, R4, R6: random frames, random jitter and chunking
        for (int k = 0; k < 40; k++) begin
            logic [12:0] raw = 13'($urandom);
            if ($urandom_range(1) == 1) pulse_start();
            run_frame(raw, 99, 1'b1, 320 + int'($urandom_range(60)), "R1 R4 R6 random");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule